// File: doc/BRIEF.md
# Operating Power Mode Transition Controller

This controller holds the chip's operating power mode and steps it from one setting to another. Software writes a 3-bit mode field. The controller reads that field back together with a read-only busy flag and a sticky error bit. When a write is accepted, the busy flag goes high and stays high for a programmable number of settling cycles. When it drops, the applied-mode output, which feeds the regulator and clock logic, takes the new value.

Two encodings are defined: 000 (high-speed, the reset value) and 010 (middle-speed). The middle-speed mode uses less power, so a request for it is checked against a per-clock over-frequency vector. The request is accepted only when every clock is already below the middle-speed ceiling. The software sequence is:
1. Wait for busy to read 0.
2. Write the mode.
3. Wait for busy to read 0 again before relying on the new mode.

Top module: `opmode_xfer_ctrl`

## Requirements
- R1: After reset, the mode field and applied mode read 000, and busy and error read 0.
- R2: A write of 000 or 010 made while busy is 0 and not rejected under R6 sets busy on the next clock edge. From that edge on, the mode field reads the written value.
- R3: Busy stays high for exactly N cycles, where N is the value on settle_len when the write is accepted. A value of 0 counts as 1.
- R4: The applied mode does not change while busy is high. It takes the value of the mode field on the same edge at which busy falls.
- R5: Any write made while busy is 1 is ignored and sets the error bit. The mode field, the busy length and the pending applied value are not changed.
- R6: A write of 010 while any bit of clk_over is 1 is rejected. Busy does not rise, both modes are kept, and the error bit is set.
- R7: A write of any encoding other than 000 or 010, made while busy is 0, is ignored. It sets no error.
- R8: The error bit stays set until err_clr is pulsed. If an error-setting write and err_clr fall in the same cycle, the bit stays set.
- R9: A write of 000 is accepted regardless of clk_over.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the mode field |
| wr_mode | input | 3 | Mode value being written |
| err_clr | input | 1 | Clears the sticky error bit |
| settle_len | input | CNT_W | Settling length in cycles, latched on acceptance |
| clk_over | input | NCLK | Per-clock flag: set when that clock exceeds the middle-speed limit |
| mode_rd | output | 3 | Mode field readback |
| busy | output | 1 | Transition in progress |
| err | output | 1 | Sticky error bit |
| applied_mode | output | 3 | Mode in effect, to regulator and clock logic |

## Verification
Two events can land in the same cycle. The first is a mode write that arrives on the last busy cycle, the same edge at which busy falls and the applied mode updates. The bench provokes it by placing the write exactly N cycles after an accepted write. It then checks three things: the write was ignored with error set, busy fell on time, and the applied mode took the earlier value. The second is err_clr given together with that faulting write. Here the error bit must remain set, and it must clear only on a later clear pulse that comes alone.

// File: rtl/opmode_xfer_ctrl.sv
module opmode_xfer_ctrl #(
  parameter int NCLK  = 5,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_mode,
  input  logic             err_clr,
  input  logic [CNT_W-1:0] settle_len,
  input  logic [NCLK-1:0]  clk_over,
  output logic [2:0]       mode_rd,
  output logic             busy,
  output logic             err,
  output logic [2:0]       applied_mode
);
  localparam logic [2:0] MODE_HS = 3'b000;
  localparam logic [2:0] MODE_MS = 3'b010;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;

  wire known   = (wr_mode == MODE_HS) || (wr_mode == MODE_MS);
  wire illegal = (wr_mode == MODE_MS) && (|clk_over);
  wire accept  = wr_en && !busy && known && !illegal;
  wire fault   = wr_en && (busy || illegal);
  wire last    = busy && (cnt_q == ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_rd      <= MODE_HS;
      applied_mode <= MODE_HS;
      busy         <= 1'b0;
      cnt_q        <= '0;
    end else if (accept) begin
      mode_rd <= wr_mode;
      busy    <= 1'b1;
      cnt_q   <= (settle_len == '0) ? ONE : settle_len;
    end else if (last) begin
      busy         <= 1'b0;
      applied_mode <= mode_rd;
    end else if (busy) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err <= 1'b0;
    else if (fault)   err <= 1'b1;
    else if (err_clr) err <= 1'b0;
  end
endmodule

// File: rtl/opmode_xfer_ctrl_chk.sv
module opmode_xfer_ctrl_chk #(
  parameter int NCLK = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [2:0]      wr_mode,
  input logic            err_clr,
  input logic [NCLK-1:0] clk_over,
  input logic [2:0]      mode_rd,
  input logic            busy,
  input logic            err,
  input logic [2:0]      applied_mode
);
  a_r2_rise_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));
  a_r4_applied_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(busy) |-> $stable(applied_mode));
  a_r4_applied_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> applied_mode == mode_rd);
  a_r5_busy_write_err: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en) |=> err && $stable(mode_rd));
  a_r6_over_reject: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && wr_mode == 3'b010 && |clk_over) |=> err && !busy && $stable(mode_rd));
  a_r7_undef_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !busy && wr_mode != 3'b000 && wr_mode != 3'b010) |=> !busy && $stable(mode_rd));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err && !err_clr) |=> err);
endmodule

bind opmode_xfer_ctrl opmode_xfer_ctrl_chk #(.NCLK(NCLK)) chk_i (.*);

// File: tb/opmode_xfer_ctrl_tb_top.sv
module opmode_xfer_ctrl_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, err_clr = 1'b0;
  logic [2:0] wr_mode = '0;
  logic [7:0] settle_len = '0;
  logic [4:0] clk_over = '0;
  logic [2:0] mode_rd, applied_mode;
  logic busy, err;
  int total = 0, bad = 0;
  logic [2:0] exp_mode = 3'b000, exp_app = 3'b000;

  always #2 clk = ~clk;

  opmode_xfer_ctrl #(.NCLK(5), .CNT_W(8)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
    chk(err == 1'b0, "R8 clear", err, 0);
  endtask

  task automatic trial(input logic [2:0] m, input logic [4:0] ov, input logic [7:0] sl);
    bit known = (m == 3'b000) || (m == 3'b010);
    bit ill = (m == 3'b010) && (ov != 0);
    bit acc = known && !ill;
    int n = (sl == 0) ? 1 : int'(sl);
    int c = 0;
    string tag = ill ? "R6" : (!known ? "R7" : ((m == 3'b000 && ov != 0) ? "R9" : "R2"));
    @(negedge clk); wr_en = 1'b1; wr_mode = m; clk_over = ov; settle_len = sl;
    @(negedge clk); wr_en = 1'b0; clk_over = '0;
    if (acc) exp_mode = m;
    chk(busy == acc, {tag, " busy"}, busy, acc);
    chk(mode_rd == exp_mode, {tag, " mode"}, mode_rd, exp_mode);
    chk(err == ill, {tag, " err"}, err, ill);
    if (acc) begin
      while (busy && c < 300) begin
        chk(applied_mode == exp_app, "R4 hold", applied_mode, exp_app);
        c++;
        @(negedge clk);
      end
      chk(c == n, "R3 length", c, n);
      exp_app = m;
      chk(applied_mode == exp_app, "R4 applied", applied_mode, exp_app);
    end else begin
      chk(applied_mode == exp_app, {tag, " applied"}, applied_mode, exp_app);
    end
    if (err) clear_err();
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mode_rd == 0 && applied_mode == 0, "R1 modes", {mode_rd, applied_mode}, 0);
    chk(busy == 0 && err == 0, "R1 flags", {busy, err}, 0);

    for (int m = 0; m < 8; m++)
      for (int p = 0; p < 7; p++)
        for (int s = 0; s < 3; s++) begin
          logic [4:0] ov = (p == 0) ? 5'd0 : (p == 6) ? 5'h1f : 5'(1 << (p - 1));
          trial(3'(m), ov, (s == 0) ? 8'd0 : (s == 1) ? 8'd1 : 8'd3);
        end

    trial(3'b000, 5'h00, 8'd1);
    @(negedge clk); wr_en = 1'b1; wr_mode = 3'b010; settle_len = 8'd3;
    @(negedge clk); wr_en = 1'b0;
    chk(busy == 1, "R2 busy", busy, 1);
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_mode = 3'b000; err_clr = 1'b1;
    @(negedge clk); wr_en = 1'b0; err_clr = 1'b0;
    chk(busy == 0, "R3 last-cycle fall", busy, 0);
    chk(err == 1, "R5 last-cycle write err", err, 1);
    chk(err == 1, "R8 set wins over clear", err, 1);
    chk(mode_rd == 3'b010, "R5 mode kept", mode_rd, 2);
    chk(applied_mode == 3'b010, "R4 applied", applied_mode, 2);
    repeat (3) @(negedge clk);
    chk(err == 1, "R8 sticky", err, 1);
    clear_err();

    @(negedge clk); wr_en = 1'b1; wr_mode = 3'b000; settle_len = 8'd4;
    @(negedge clk); wr_mode = 3'b010;
    @(negedge clk); wr_en = 1'b0;
    chk(err == 1 && busy == 1, "R5 mid-busy write", {err, busy}, 3);
    chk(mode_rd == 3'b000, "R5 mode kept", mode_rd, 0);
    repeat (2) @(negedge clk);
    chk(busy == 1, "R5 length unchanged", busy, 1);
    @(negedge clk);
    chk(busy == 0 && applied_mode == 3'b000, "R3 R4 end", {busy, applied_mode}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule